// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A memory controller samples the mode-register word when it issues a column command. It supplies the starting column with a one-cycle command strobe. From the next clock the block presents one column address per clock. It raises a burst-active flag for the whole burst and pulses a last-beat flag on the final beat of a fixed-length burst.

The mode word selects how many beats a burst has (1, 2, 4, 8 or a full row). It also selects whether beats count upward or follow the XOR-interleaved order, and whether writes are forced to a single beat. Fixed-length bursts stay inside the aligned block that holds the start column. A full-row burst walks the whole row and wraps without end, so it needs an explicit stop. A column command given while a burst is running replaces that burst at once. This allows a fresh column on every clock.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While reset (rstN low) is applied and after it is released with no command, burstActive and lastBeat are 0.
- R2: modeWord[2:0] sets the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives a full row; 100, 101 and 110 give 1 beat.
- R3: With modeWord[3]=0, beat i of a fixed length-L burst has address (start with its low log2(L) bits cleared) plus ((start mod L) + i) mod L.
- R4: With modeWord[3]=1 and length 4 or 8, beat i has the start address with its low log2(L) bits XORed with i. At lengths 1 and 2 the order is the same as in R3.
- R5: A full-row burst (code 111) gives addresses (start + i) mod NUM_COLS for as long as it runs. lastBeat never rises, and the burst ends only by stopReq or by a new command.
- R6: stopReq without cmdValid ends a running burst: burstActive is 0 from the next cycle.
- R7: When modeWord[9]=1, a write command (cmdWrite=1) gives a single-beat burst, and reads keep the length from R2. When modeWord[9]=0, writes also follow R2.
- R8: cmdValid during a running burst ends that burst and starts a new one at beat 0 on the new column. cmdValid given in the same cycle as stopReq starts the new burst.
- R9: lastBeat is 1 exactly in the cycle of a fixed burst's final beat, and burstActive is 0 in the cycle after it unless a new command was given.
- R10: A command sampled at a clock edge shows its start column on colAddr with burstActive=1 in the cycle after that edge. A command is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 10 | Mode-register word, sampled with each command |
| cmdValid | input | 1 | Read or write column command strobe |
| cmdWrite | input | 1 | 1 marks the command as a write |
| cmdCol | input | COL_W | Start column of the command |
| stopReq | input | 1 | Burst stop or precharge of the active bank |
| colAddr | output | COL_W | Column address of the current beat |
| burstActive | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
A wrong beat counter or captured mode shows on colAddr within one beat. Examples are a wrong low-bit order, a carry into the upper bits, or an XOR where an add belongs. The bench therefore compares every beat of every burst with a model computed from the start column and the length. A wrong length or lost stop shows as burstActive or lastBeat being wrong within one cycle of the expected final beat. Full-row bursts run past the row end to expose a wrap error. Restart and same-cycle command/stop cases expose wrong priority in the cycle after the command.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  localparam int MODE_W      = 10;
  localparam int ORDER_BIT   = 3;
  localparam int WSINGLE_BIT = 9;

  typedef struct packed {
    logic       fullPage;
    logic [1:0] lenLog;
  } len_cfg_t;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic       loadStart;
    logic       interleave;
    logic       fullPage;
    logic [1:0] lenLog;
  } burst_strobe_t;

  function automatic len_cfg_t decodeLen(input logic [2:0] code);
    len_cfg_t cfg;
    cfg = '0;
    case (code)
      3'b001:  cfg.lenLog = 2'd1;
      3'b010:  cfg.lenLog = 2'd2;
      3'b011:  cfg.lenLog = 2'd3;
      3'b111:  cfg.fullPage = 1'b1;
      default: cfg.lenLog = 2'd0;
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    modeWord,
  input  logic                 cmdValid,
  input  logic                 cmdWrite,
  input  logic                 stopReq,
  output burst_strobe_t        strb,
  output logic [COL_W-1:0]     beatCnt,
  output logic                 burstActive,
  output logic                 lastBeat
);

  logic             activeQ;
  logic [COL_W-1:0] cntQ;
  logic             fullQ;
  logic             intlQ;
  logic [1:0]       lenLogQ;
  logic [COL_W-1:0] endCnt;
  len_cfg_t         newCfg;
  logic             newIntl;

  always_comb begin
    newCfg = decodeLen(modeWord[2:0]);
    if (cmdWrite && modeWord[WSINGLE_BIT]) begin
      newCfg = '0;
    end
    newIntl = modeWord[ORDER_BIT] && !newCfg.fullPage && (newCfg.lenLog >= 2'd2);
  end

  assign endCnt      = COL_W'((32'd1 << lenLogQ) - 32'd1);
  assign lastBeat    = activeQ && !fullQ && (cntQ == endCnt);
  assign burstActive = activeQ;
  assign beatCnt     = cntQ;

  always_comb begin
    strb.loadStart  = cmdValid;
    strb.interleave = intlQ;
    strb.fullPage   = fullQ;
    strb.lenLog     = lenLogQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
      fullQ   <= 1'b0;
      intlQ   <= 1'b0;
      lenLogQ <= 2'd0;
    end else if (cmdValid) begin
      activeQ <= 1'b1;
      cntQ    <= '0;
      fullQ   <= newCfg.fullPage;
      intlQ   <= newIntl;
      lenLogQ <= newCfg.lenLog;
    end else if (stopReq || lastBeat) begin
      activeQ <= 1'b0;
    end else if (activeQ) begin
      cntQ <= cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  burst_strobe_t        strb,
  input  logic [COL_W-1:0]     beatCnt,
  input  logic [COL_W-1:0]     cmdCol,
  output logic [COL_W-1:0]     colAddr
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] wrapMask;
  logic [COL_W-1:0] lowPart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
    end else if (strb.loadStart) begin
      startQ <= cmdCol;
    end
  end

  assign wrapMask = strb.fullPage ? '1 : COL_W'((32'd1 << strb.lenLog) - 32'd1);

  generate
    if (COL_W >= 3) begin : g_order
      assign lowPart = strb.interleave ? (startQ ^ beatCnt) : (startQ + beatCnt);
    end else begin : g_seq_only
      assign lowPart = startQ + beatCnt;
    end
  endgenerate

  assign colAddr = (startQ & ~wrapMask) | (lowPart & wrapMask);

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
  import sdram_burst_pkg::*;
#(
  parameter int NUM_COLS = 256,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    modeWord,
  input  logic                 cmdValid,
  input  logic                 cmdWrite,
  input  logic [COL_W-1:0]     cmdCol,
  input  logic                 stopReq,
  output logic [COL_W-1:0]     colAddr,
  output logic                 burstActive,
  output logic                 lastBeat
);

  burst_strobe_t    strb;
  logic [COL_W-1:0] beatCnt;

  sdram_burst_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .stopReq(stopReq), .strb(strb), .beatCnt(beatCnt),
    .burstActive(burstActive), .lastBeat(lastBeat)
  );

  sdram_burst_dp #(.COL_W(COL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .beatCnt(beatCnt),
    .cmdCol(cmdCol), .colAddr(colAddr)
  );

endmodule

// File: rtl/sdram_col_burst_chk.sv
module sdram_col_burst_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [COL_W-1:0] cmdCol,
  input logic             stopReq,
  input logic [COL_W-1:0] colAddr,
  input logic             burstActive,
  input logic             lastBeat
);

  // R9
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> burstActive);

  // R9
  ends_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !cmdValid) |=> !burstActive);

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !cmdValid) |=> !burstActive);

  // R10
  cmd_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (burstActive && colAddr == $past(cmdCol)));

  // R5
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !lastBeat && !stopReq && !cmdValid) |=> burstActive);

endmodule

bind sdram_col_burst_gen sdram_col_burst_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCol(cmdCol),
  .stopReq(stopReq), .colAddr(colAddr), .burstActive(burstActive),
  .lastBeat(lastBeat)
);

// File: tb/sdram_col_burst_gen_tb.sv
`timescale 1ns/1ps
module sdram_col_burst_gen_tb_top;

  localparam int NCOL = 256;
  localparam int CW   = 8;
  localparam int NVEC = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [9:0]    modeWord = '0;
  logic          cmdValid = 1'b0;
  logic          cmdWrite = 1'b0;
  logic [CW-1:0] cmdCol = '0;
  logic          stopReq = 1'b0;
  logic [CW-1:0] colAddr;
  logic          burstActive;
  logic          lastBeat;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sdram_col_burst_gen #(.NUM_COLS(NCOL)) dut_i (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .cmdCol(cmdCol), .stopReq(stopReq),
    .colAddr(colAddr), .burstActive(burstActive), .lastBeat(lastBeat)
  );

  // Each vector: {mode[9:0], write, start column}
  localparam logic [18:0] VEC [NVEC] = '{
    {10'h000, 1'b0, 8'h05},  // R2 one beat
    {10'h001, 1'b0, 8'h07},  // R3 two beats, wrap
    {10'h002, 1'b0, 8'h0E},  // R3 four beats
    {10'h003, 1'b0, 8'h2D},  // R3 eight beats
    {10'h00A, 1'b0, 8'h0D},  // R4 interleave four
    {10'h00B, 1'b0, 8'h2B},  // R4 interleave eight
    {10'h009, 1'b0, 8'h07},  // R4 interleave two = sequential
    {10'h007, 1'b0, 8'hF0},  // R5 full row
    {10'h004, 1'b0, 8'h20},  // R2 unused code
    {10'h203, 1'b1, 8'h11},  // R7 write single
    {10'h203, 1'b0, 8'h11},  // R7 read keeps length
    {10'h003, 1'b1, 8'h11},  // R7 write without single mode
    {10'h006, 1'b0, 8'h3C}   // R2 unused code
  };
  localparam int VTAG [NVEC] = '{2, 3, 3, 3, 4, 4, 4, 5, 2, 7, 7, 7, 2};

  // Burst length from the requirements; 0 means full row.
  function automatic int expLen(input logic [9:0] m, input logic wr);
    int n;
    case (m[2:0])
      3'd1: n = 2;
      3'd2: n = 4;
      3'd3: n = 8;
      3'd7: n = 0;
      default: n = 1;
    endcase
    if (wr && m[9]) n = 1;
    return n;
  endfunction

  function automatic int expAddr(input logic [9:0] m, input logic wr, input int s, input int i);
    int n, base, off;
    n = expLen(m, wr);
    if (n == 0) return (s + i) % NCOL;
    base = s - (s % n);
    off  = s % n;
    if (m[3] && n >= 4) return base + (off ^ (i % n));
    return base + ((off + i) % n);
  endfunction

  task automatic check(input int tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [9:0] m, input logic wr, input logic [7:0] col);
    modeWord = m; cmdWrite = wr; cmdCol = col; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic runBurst(input logic [9:0] m, input logic wr, input logic [7:0] col, input int tag);
    int n, beats;
    n = expLen(m, wr);
    beats = (n == 0) ? 300 : n;
    issue(m, wr, col);
    for (int i = 0; i < beats; i++) begin
      check(tag, "address", colAddr, expAddr(m, wr, col, i));
      check(tag, "active", burstActive, 1);
      check(tag, "last", lastBeat, (n != 0 && i == beats - 1) ? 1 : 0);
      if (n == 0 && i == beats - 1) stopReq = 1'b1;
      @(negedge clk);
      stopReq = 1'b0;
    end
    check(tag, "idle after burst", burstActive, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, "active in reset", burstActive, 0);   // R1
    check(1, "last in reset", lastBeat, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "active after reset", burstActive, 0);

    for (int v = 0; v < NVEC; v++) begin
      runBurst(VEC[v][18:9], VEC[v][8], VEC[v][7:0], VTAG[v]);
    end

    // R8: restart in the middle of an eight-beat burst
    issue(10'h003, 1'b0, 8'h10);
    check(8, "first burst beat0", colAddr, 8'h10);
    @(negedge clk);
    @(negedge clk);
    check(8, "first burst beat2", colAddr, 8'h12);
    issue(10'h002, 1'b0, 8'h45);
    check(8, "restart col", colAddr, 8'h45);
    check(8, "restart last", lastBeat, 0);
    @(negedge clk); check(8, "restart beat1", colAddr, 8'h46);
    @(negedge clk); check(8, "restart beat2", colAddr, 8'h47);
    @(negedge clk); check(8, "restart beat3", colAddr, 8'h44);
    check(9, "restart final last", lastBeat, 1);
    @(negedge clk); check(9, "idle after restart", burstActive, 0);

    // R8: command together with stop starts the new burst
    stopReq = 1'b1;
    issue(10'h003, 1'b0, 8'h30);
    stopReq = 1'b0;
    check(8, "cmd wins over stop", burstActive, 1);
    check(8, "cmd wins col", colAddr, 8'h30);
    @(negedge clk);
    stopReq = 1'b1;                                   // R6 stop mid burst
    @(negedge clk);
    stopReq = 1'b0;
    check(6, "stop ends burst", burstActive, 0);
    check(6, "stop no last", lastBeat, 0);

    // R10: a command on every clock
    modeWord = 10'h003; cmdWrite = 1'b0; cmdValid = 1'b1;
    cmdCol = 8'h81; @(negedge clk);
    check(10, "b2b col0", colAddr, 8'h81);
    cmdCol = 8'h9A; @(negedge clk);
    check(10, "b2b col1", colAddr, 8'h9A);
    cmdCol = 8'h33; @(negedge clk);
    check(10, "b2b col2", colAddr, 8'h33);
    cmdValid = 1'b0;
    @(negedge clk);
    check(10, "b2b continues", colAddr, 8'h34);
    check(10, "b2b active", burstActive, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule